// File: doc/BRIEF.md
# Serial Command Sequencer with Status Reply

This block turns a stream of command bytes into operations on a small non-volatile style memory model. It takes one opcode byte, then gathers the address and data bytes that this opcode calls for, and carries out reads, sequential reads, single-location writes and erases, and whole-array erase and fill. Any change to the array runs as a self-timed program cycle whose length is a parameter counted in clock cycles. The array holds 2^ADDR_W bytes and can be seen either as bytes or as 16-bit words. Word w occupies byte 2w, which holds the high half, and byte 2w+1, which holds the low half.

Command bytes arrive on a valid/ready input. A byte transfers on a clock edge where in_valid and in_ready are both high. in_ready is low while a reply is being sent and during the one execute cycle after the last byte of a command. Reply bytes leave on a valid/ready output. While out_valid is high and out_ready is low, out_valid and out_data stay unchanged until the transfer. The select input frames everything. While sel is low, input is not taken and no reply is offered. The falling of sel aborts the command being parsed or sent and clears a halt. It does not stop a program cycle that is already running, and it does not clear the mode flags. The external allow input grants or refuses each program operation at the moment it would start.

The block keeps three mode flags: program enable, busy indication and the 16-bit organization. It also keeps two error bits, and it can show the program cycle as a level on a shared data line through busy_oe and busy_lvl.

Top module: `cmdseq_core`

## Requirements
- R1: After reset, fault is 0, out_valid is 0, busy_oe is 0, in_ready is 1 and a status request returns 8'hA0. The array holds all ones.
- R2: Byte organization (the reset default, also selected by 8'h86). Write 8'hC1 takes an address high byte, an address low byte and one data byte. Read 8'hC9 takes two address bytes and returns one byte, and this byte equals the stored value.
- R3: Word organization (selected by 8'h87). Write takes one address byte and then the data high byte followed by the data low byte. Read takes one address byte and returns the high byte, then the low byte. Word w is the same storage as bytes 2w (high) and 2w+1 (low).
- R4: Erase 8'hC0 takes the same address bytes as a read and sets the addressed location to all ones.
- R5: Program operations are write, erase, erase-all and write-all. They change the array only if program enable is set (8'h81 sets it, 8'h82 clears it) and allow is high when the command executes. Otherwise the array is unchanged and no program cycle starts.
- R6: Status 8'hC8 returns {3'b101, parity error, instruction error, busy, 2'b00}. It reads 8'hA4 while a program cycle runs and 8'hA0 when idle. The value is taken when the request is accepted. A program cycle lasts exactly PROG_CYCLES clock cycles.
- R7: An unknown opcode sets instruction error and raises fault. After that the block takes and discards all input bytes and gives no reply until sel is pulsed low, and the pulse lowers fault. The error bits stay set until a status reply is sent, and the reply clears them.
- R8: A byte taken with in_perr high sets parity error and halts the block in the same way as R7. A status request after a sel pulse then reads 8'hB0.
- R9: A sel pulse does not clear program enable or busy indication.
- R10: Erase-all 8'h89 sets every byte to all ones only when it arrives directly after another 8'h89. A single 8'h89 only arms the second step, and any other opcode disarms it.
- R11: Write-all 8'hC3 takes one data byte in byte organization, or two in word organization, and fills the whole array. It is legal only directly after a single arming 8'h89. Without that arming it is an instruction error.
- R12: With busy indication on (8'h84 sets it, 8'h85 clears it), busy_oe is 1 and busy_lvl is 0 during a program cycle. When the cycle ends, busy_lvl becomes 1 and busy_oe stays 1 until the next opcode is taken, and then busy_oe goes to 0. With busy indication off, busy_oe stays 0.
- R13: Sequential read 8'hCB takes a start address and returns the locations from that address upward to the last one, then stops. When sel goes low, the stream stops and out_valid goes to 0. Under back-pressure, out_valid and out_data hold.
- R14: While a program cycle runs, any opcode other than status is an instruction error and halts the block as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Select; low aborts the current command and clears a halt |
| allow | input | 1 | Grants a program operation when it starts |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte can be taken |
| in_data | input | 8 | Command byte |
| in_perr | input | 1 | Parity error reported by the link for this byte |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Receiver takes the reply byte |
| out_data | output | 8 | Reply byte |
| busy_oe | output | 1 | Drive enable for the busy level on the shared line |
| busy_lvl | output | 1 | Level to drive: 0 busy, 1 ready |
| fault | output | 1 | High while halted by an error |

## Verification
Two events can fall in the same cycle: a status request is accepted while a program cycle is active, or a new opcode arrives while the cycle is running. The bench provokes both by sending a status request or a no-operation byte directly behind a write's last data byte, so that the byte is taken in the cycle after the cycle is launched. It then judges the status reply, which must read 8'hA4, and checks that fault rises on the rejected byte. The bench also counts, cycle by cycle, the span during which the busy level is driven low, and checks that the level goes high at once when the span ends and floats after the next opcode.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  localparam logic [7:0] OP_NOP    = 8'h80;
  localparam logic [7:0] OP_PEN    = 8'h81;
  localparam logic [7:0] OP_PDIS   = 8'h82;
  localparam logic [7:0] OP_OVR    = 8'h83;
  localparam logic [7:0] OP_BEN    = 8'h84;
  localparam logic [7:0] OP_BDIS   = 8'h85;
  localparam logic [7:0] OP_ORG8   = 8'h86;
  localparam logic [7:0] OP_ORG16  = 8'h87;
  localparam logic [7:0] OP_LOCK   = 8'h88;
  localparam logic [7:0] OP_ERALL  = 8'h89;
  localparam logic [7:0] OP_ERASE  = 8'hC0;
  localparam logic [7:0] OP_WRITE  = 8'hC1;
  localparam logic [7:0] OP_WRALL  = 8'hC3;
  localparam logic [7:0] OP_PTR    = 8'hC4;
  localparam logic [7:0] OP_STAT   = 8'hC8;
  localparam logic [7:0] OP_READ   = 8'hC9;
  localparam logic [7:0] OP_RSEQ   = 8'hCB;

  localparam logic [2:0] STAT_SIG  = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_EXEC,
    ST_SEND,
    ST_HALT
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ,
    K_RSEQ,
    K_WRITE,
    K_ERASE,
    K_ERALL,
    K_WRALL,
    K_STAT
  } cmd_kind_t;

endpackage

// File: rtl/cmdseq_ptimer.sv
module cmdseq_ptimer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R6: a launched cycle is visible as busy on the next cycle
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/cmdseq_array.sv
module cmdseq_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          fin,
  input  logic          all,
  input  logic          wide,
  input  logic [AW-1:0] base,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  localparam int NB = 1 << AW;

  logic [7:0]    mem [NB];
  logic          p_all;
  logic          p_wide;
  logic [AW-1:0] p_base;
  logic [15:0]   p_data;

  function automatic logic hit(input logic [AW-1:0] i, input logic [AW-1:0] b,
                               input logic w);
    return w ? (i[AW-1:1] == b[AW-1:1]) : (i == b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_all  <= 1'b0;
      p_wide <= 1'b0;
      p_base <= '0;
      p_data <= 16'hFFFF;
    end else if (go) begin
      p_all  <= all;
      p_wide <= wide;
      p_base <= base;
      p_data <= wdata;
    end
  end

  // erase phase at launch, program phase at the end of the cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (go && (all || hit(AW'(i), base, wide)))
          mem[i] <= 8'hFF;
        else if (fin && (p_all || hit(AW'(i), p_base, p_wide)))
          mem[i] <= p_wide ? ((i % 2 == 1) ? p_data[7:0] : p_data[15:8])
                           : p_data[7:0];
      end
    end
  end

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl import cmdseq_pkg::*; #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          allow,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_perr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  input  logic          busy,
  input  logic          done,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] rd_idx,
  output logic          go,
  output logic          all,
  output logic          wide,
  output logic [AW-1:0] base,
  output logic [15:0]   wdata,
  output logic          busy_oe,
  output logic          busy_lvl,
  output logic          fault
);
  localparam int WAW = AW - 1;

  seq_state_t    st;
  cmd_kind_t     kind;
  logic [1:0]    na, nd;
  logic [AW-1:0] addr_sh;
  logic [15:0]   data_sh;
  logic [AW-1:0] cur;
  logic          ph;
  logic [7:0]    stat_q;
  logic          prog_en, bsy_en, x16, armed;
  logic          perr, ierr, ready_hi;
  logic          acc;
  logic [AW-1:0] last_w;
  logic          prog_kind;

  assign acc    = in_valid && in_ready;
  assign last_w = x16 ? {1'b0, {WAW{1'b1}}} : {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= K_NONE;
      na       <= '0;
      nd       <= '0;
      addr_sh  <= '0;
      data_sh  <= '0;
      cur      <= '0;
      ph       <= 1'b0;
      stat_q   <= '0;
      prog_en  <= 1'b0;
      bsy_en   <= 1'b0;
      x16      <= 1'b0;
      armed    <= 1'b0;
      perr     <= 1'b0;
      ierr     <= 1'b0;
      ready_hi <= 1'b0;
    end else if (!sel) begin
      st       <= ST_IDLE;
      armed    <= 1'b0;
      ph       <= 1'b0;
      ready_hi <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          ready_hi <= 1'b0;
          armed    <= 1'b0;
          if (in_perr) begin
            perr <= 1'b1;
            st   <= ST_HALT;
          end else if (busy && in_data != OP_STAT) begin
            ierr <= 1'b1;
            st   <= ST_HALT;
          end else begin
            case (in_data)
              OP_NOP, OP_OVR, OP_LOCK: ;
              OP_PEN:   prog_en <= 1'b1;
              OP_PDIS:  prog_en <= 1'b0;
              OP_BEN:   bsy_en  <= 1'b1;
              OP_BDIS:  bsy_en  <= 1'b0;
              OP_ORG8:  x16     <= 1'b0;
              OP_ORG16: x16     <= 1'b1;
              OP_ERALL: begin
                if (armed) begin
                  kind <= K_ERALL;
                  st   <= ST_EXEC;
                end else begin
                  armed <= 1'b1;
                end
              end
              OP_ERASE, OP_READ, OP_RSEQ, OP_PTR: begin
                kind <= (in_data == OP_ERASE) ? K_ERASE :
                        (in_data == OP_READ)  ? K_READ  :
                        (in_data == OP_RSEQ)  ? K_RSEQ  : K_NONE;
                na   <= x16 ? 2'd1 : 2'd2;
                nd   <= 2'd0;
                st   <= ST_COLLECT;
              end
              OP_WRITE: begin
                kind <= K_WRITE;
                na   <= x16 ? 2'd1 : 2'd2;
                nd   <= x16 ? 2'd2 : 2'd1;
                st   <= ST_COLLECT;
              end
              OP_WRALL: begin
                if (armed) begin
                  kind <= K_WRALL;
                  na   <= 2'd0;
                  nd   <= x16 ? 2'd2 : 2'd1;
                  st   <= ST_COLLECT;
                end else begin
                  ierr <= 1'b1;
                  st   <= ST_HALT;
                end
              end
              OP_STAT: begin
                kind   <= K_STAT;
                stat_q <= {STAT_SIG, perr, ierr, busy, 2'b00};
                st     <= ST_SEND;
              end
              default: begin
                ierr <= 1'b1;
                st   <= ST_HALT;
              end
            endcase
          end
        end
        ST_COLLECT: if (acc) begin
          if (in_perr) begin
            perr <= 1'b1;
            st   <= ST_HALT;
          end else if (na != 2'd0) begin
            addr_sh <= {addr_sh[AW-9:0], in_data};
            na      <= na - 2'd1;
            if (na == 2'd1 && nd == 2'd0) st <= ST_EXEC;
          end else begin
            data_sh <= {data_sh[7:0], in_data};
            nd      <= nd - 2'd1;
            if (nd == 2'd1) st <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          cur <= x16 ? {1'b0, addr_sh[WAW-1:0]} : addr_sh;
          ph  <= 1'b0;
          st  <= (kind == K_READ || kind == K_RSEQ) ? ST_SEND : ST_IDLE;
        end
        ST_SEND: if (out_ready) begin
          if (kind == K_STAT) begin
            perr <= 1'b0;
            ierr <= 1'b0;
            st   <= ST_IDLE;
          end else if (x16 && !ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (kind == K_RSEQ && cur != last_w) cur <= cur + AW'(1);
            else st <= ST_IDLE;
          end
        end
        ST_HALT: ;
        default: st <= ST_IDLE;
      endcase
      if (done && bsy_en) ready_hi <= 1'b1;
    end
  end

  assign prog_kind = (kind == K_WRITE) || (kind == K_ERASE) ||
                     (kind == K_ERALL) || (kind == K_WRALL);

  assign in_ready  = sel && (st == ST_IDLE || st == ST_COLLECT || st == ST_HALT);
  assign out_valid = sel && (st == ST_SEND);
  assign out_data  = (kind == K_STAT) ? stat_q : rd_byte;
  assign rd_idx    = x16 ? {cur[WAW-1:0], ph} : cur;
  assign go        = sel && (st == ST_EXEC) && prog_kind && prog_en && allow;
  assign all       = (kind == K_ERALL) || (kind == K_WRALL);
  assign wide      = x16;
  assign base      = x16 ? {addr_sh[WAW-1:0], 1'b0} : addr_sh;
  assign wdata     = (kind == K_WRITE || kind == K_WRALL)
                     ? (x16 ? data_sh : {8'hFF, data_sh[7:0]}) : 16'hFFFF;
  assign busy_oe   = sel && ((bsy_en && busy) || ready_hi);
  assign busy_lvl  = !busy;
  assign fault     = (st == ST_HALT);

  // R13: a held reply byte does not change while sel stays high
  assert_reply_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && out_valid && !out_ready) |=> (!sel || (out_valid && $stable(out_data))));

  // R14: no program cycle launches on top of a running one
  assert_no_overlap_R14: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

  // R7: a halted block neither launches nor replies
  assert_halt_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!go && !out_valid));

  // R8: a byte flagged by the link halts the block
  assert_parity_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_perr) |=> fault);

endmodule

// File: rtl/cmdseq_core.sv
module cmdseq_core #(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       allow,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_perr,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       busy_oe,
  output logic       busy_lvl,
  output logic       fault
);
  logic              go, all, wide, busy, done;
  logic [ADDR_W-1:0] base, rd_idx;
  logic [15:0]       wdata;
  logic [7:0]        rd_byte;

  cmdseq_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .allow(allow),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_perr(in_perr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .done(done), .rd_byte(rd_byte), .rd_idx(rd_idx),
    .go(go), .all(all), .wide(wide), .base(base), .wdata(wdata),
    .busy_oe(busy_oe), .busy_lvl(busy_lvl), .fault(fault)
  );

  cmdseq_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(go), .busy(busy), .done(done)
  );

  cmdseq_array #(.AW(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .go(go), .fin(done), .all(all), .wide(wide),
    .base(base), .wdata(wdata), .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

endmodule

// File: tb/cmdseq_core_test.sv
module cmdseq_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n, sel, allow, in_valid, in_perr, out_ready;
  logic [7:0] in_data;
  logic in_ready, out_valid, busy_oe, busy_lvl, fault;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdseq_core #(.ADDR_W(9), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .allow(allow),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_perr(in_perr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy_oe(busy_oe), .busy_lvl(busy_lvl), .fault(fault)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every reply transfer
  always @(negedge clk) begin
    if (!finished && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL unexpected reply actual %0h expected none", out_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
  end

  task automatic expect_b(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b, input logic p);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_perr = p;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_perr = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_prog();
    repeat (PROG + 6) @(negedge clk);
  endtask

  task automatic sel_pulse();
    @(negedge clk); sel = 1'b0;
    @(negedge clk); sel = 1'b1;
    @(negedge clk);
  endtask

  task automatic status(input logic [7:0] e, input string tag);
    expect_b(e, tag);
    send(8'hC8, 1'b0);
    drain();
  endtask

  task automatic wr8(input logic [15:0] a, input logic [7:0] d);
    send(8'hC1, 1'b0); send(a[15:8], 1'b0); send(a[7:0], 1'b0); send(d, 1'b0);
  endtask

  task automatic rd8(input logic [15:0] a, input logic [7:0] e, input string tag);
    expect_b(e, tag);
    send(8'hC9, 1'b0); send(a[15:8], 1'b0); send(a[7:0], 1'b0);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 1'b1; allow = 1'b1; in_valid = 1'b0; in_perr = 1'b0;
    in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(fault == 1'b0, "R1 fault", fault, 0);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(busy_oe == 1'b0, "R1 busy_oe", busy_oe, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    status(8'hA0, "R1 status idle");
    rd8(16'h0003, 8'hFF, "R1 array erased");

    // R5 write without program enable is dropped
    wr8(16'h0005, 8'h3C);
    status(8'hA0, "R5 no cycle");
    rd8(16'h0005, 8'hFF, "R5 no enable");

    // R2 byte organization write and read, R6 status while busy
    send(8'h81, 1'b0);
    wr8(16'h0005, 8'h3C);
    status(8'hA4, "R6 status busy");
    wait_prog();
    status(8'hA0, "R6 status idle after");
    rd8(16'h0005, 8'h3C, "R2 read back");
    wr8(16'h01FE, 8'h5A);
    wait_prog();
    rd8(16'h01FE, 8'h5A, "R2 high address");

    // R5 allow low refuses
    allow = 1'b0;
    wr8(16'h0006, 8'h11);
    status(8'hA0, "R5 allow low no cycle");
    allow = 1'b1;
    rd8(16'h0006, 8'hFF, "R5 allow low");

    // R4 erase
    send(8'hC0, 1'b0); send(8'h00, 1'b0); send(8'h05, 1'b0);
    wait_prog();
    rd8(16'h0005, 8'hFF, "R4 erase");

    // R12 and R6 busy line and cycle length
    send(8'h84, 1'b0);
    wr8(16'h0008, 8'h88);
    begin
      int lowc = 0;
      for (int k = 0; k < 4 * PROG; k++) begin
        if (busy_oe && busy_lvl) break;
        if (busy_oe && !busy_lvl) lowc++;
        @(negedge clk);
      end
      check(lowc == PROG, "R6 cycle length", lowc, PROG);
    end
    check(busy_oe && busy_lvl, "R12 ready high", {busy_oe, busy_lvl}, 3);
    repeat (4) @(negedge clk);
    check(busy_oe && busy_lvl, "R12 ready held", {busy_oe, busy_lvl}, 3);
    send(8'h80, 1'b0);
    check(busy_oe == 1'b0, "R12 float after opcode", busy_oe, 0);
    send(8'h85, 1'b0);
    wr8(16'h0009, 8'h99);
    repeat (5) @(negedge clk);
    check(busy_oe == 1'b0, "R12 indication off", busy_oe, 0);
    wait_prog();

    // R14 opcode during a cycle
    wr8(16'h000A, 8'hAA);
    send(8'h80, 1'b0);
    check(fault == 1'b1, "R14 reject during cycle", fault, 1);
    wait_prog();
    // R7 halted block ignores input
    send(8'hC8, 1'b0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7 no reply when halted", out_valid, 0);
    sel_pulse();
    check(fault == 1'b0, "R7 sel clears halt", fault, 0);
    status(8'hA8, "R14 instruction error bit");
    status(8'hA0, "R7 bits cleared by read");

    // R7 unknown opcode
    send(8'h55, 1'b0);
    check(fault == 1'b1, "R7 unknown opcode", fault, 1);
    sel_pulse();
    status(8'hA8, "R7 status after unknown");

    // R8 parity error
    send(8'h80, 1'b1);
    check(fault == 1'b1, "R8 parity halts", fault, 1);
    sel_pulse();
    status(8'hB0, "R8 status parity");

    // R9 flags survive a sel pulse
    send(8'h84, 1'b0);
    sel_pulse();
    wr8(16'h0007, 8'h77);
    repeat (5) @(negedge clk);
    check(busy_oe && !busy_lvl, "R9 busy indication kept", {busy_oe, busy_lvl}, 2);
    wait_prog();
    send(8'h85, 1'b0);
    rd8(16'h0007, 8'h77, "R9 program enable kept");

    // R3 word organization
    send(8'h87, 1'b0);
    send(8'hC1, 1'b0); send(8'h10, 1'b0); send(8'hBE, 1'b0); send(8'hEF, 1'b0);
    wait_prog();
    expect_b(8'hBE, "R3 word high");
    expect_b(8'hEF, "R3 word low");
    send(8'hC9, 1'b0); send(8'h10, 1'b0);
    drain();
    send(8'h86, 1'b0);
    rd8(16'h0020, 8'hBE, "R3 byte view high");
    rd8(16'h0021, 8'hEF, "R3 byte view low");

    // R13 sequential read to the end
    expect_b(8'hFF, "R13 seq 509");
    expect_b(8'h5A, "R13 seq 510");
    expect_b(8'hFF, "R13 seq 511");
    send(8'hCB, 1'b0); send(8'h01, 1'b0); send(8'hFD, 1'b0);
    drain();
    check(out_valid == 1'b0, "R13 stream stopped", out_valid, 0);
    status(8'hA0, "R13 idle after stream");
    // R13 back-pressure and sel abort
    out_ready = 1'b0;
    send(8'hCB, 1'b0); send(8'h00, 1'b0); send(8'h07, 1'b0);
    repeat (2) @(negedge clk);
    begin
      logic [7:0] held;
      held = out_data;
      check(out_valid == 1'b1, "R13 reply offered", out_valid, 1);
      check(held == 8'h77, "R13 first stream byte", held, 8'h77);
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1 && out_data == held, "R13 held under back-pressure",
            out_data, held);
    end
    sel = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R13 sel stops stream", out_valid, 0);
    sel = 1'b1;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R13 stays stopped", out_valid, 0);

    // R10 two-step erase-all
    send(8'h89, 1'b0); send(8'h80, 1'b0); send(8'h89, 1'b0); send(8'h80, 1'b0);
    status(8'hA0, "R10 no cycle when broken");
    rd8(16'h01FE, 8'h5A, "R10 broken pair keeps data");
    send(8'h89, 1'b0); send(8'h89, 1'b0);
    wait_prog();
    rd8(16'h01FE, 8'hFF, "R10 erase-all");
    rd8(16'h0007, 8'hFF, "R10 erase-all low");

    // R11 write-all
    send(8'hC3, 1'b0);
    check(fault == 1'b1, "R11 unarmed write-all", fault, 1);
    sel_pulse();
    status(8'hA8, "R11 status after unarmed");
    send(8'h89, 1'b0); send(8'hC3, 1'b0); send(8'h42, 1'b0);
    wait_prog();
    rd8(16'h0000, 8'h42, "R11 write-all first");
    rd8(16'h01FF, 8'h42, "R11 write-all last");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule